// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block sits next to a 16-bit processor core and decides, at each instruction boundary, whether a pending interrupt is taken. It watches two active-low request lines. The first is a maskable request that carries a 4-bit priority level. The second is a non-maskable request. The block holds a 4-bit priority mask. The core can load that mask with an immediate-load command.

When the core signals that an instruction has completed, the block samples both request lines. The non-maskable line always wins. Its vector is the fixed word 0xFFFC, and the core fetches the new program counter from the next word, 0xFFFE. A maskable request is taken only if its level does not exceed the mask. When it is taken, the block emits a vector of level times four and lowers the mask by one.

Both request lines are level sensitive. A line that is held low is therefore taken again at every boundary where it still qualifies. Saving context, fetching from memory and running the handler are left to the core.

Top module: `irq_vector_unit`

## Requirements
- R1: Requests are sampled only on a clock edge where `boundary_i` is 1. A request line that is high (inactive) at that edge, or a request that is low while `boundary_i` is 0, produces no take.
- R2: A maskable request (`mreq_n_i` = 0) is accepted when `mlevel_i` is less than or equal to the effective mask. Otherwise it is ignored and no take occurs.
- R3: The vector for an accepted maskable request is `mlevel_i` × 4. Level 0 gives 0x0000, level 1 gives 0x0004 and level 15 gives 0x003C.
- R4: Accepting a maskable request lowers the mask by one. A mask that is already 0 stays at 0.
- R5: When `mask_load_i` is 1, the mask takes `mask_value_i`, which may be any value from 0 to 15, on that edge. Level 0 is accepted at every mask value.
- R6: A non-maskable request (`nmi_n_i` = 0) at a boundary is always taken. It produces vector 0xFFFC, drives `take_nmi_o` to 1 and leaves the mask unchanged.
- R7: Because both lines are level sensitive, a request that stays asserted and still qualifies is taken again at every boundary.
- R8: When both lines are pending at the same boundary, only the non-maskable request is taken.
- R9: `take_o` is a single-clock pulse in the cycle after the boundary edge. `vector_o`, `take_nmi_o` and the updated `mask_o` are valid in that same cycle. `vector_o` and `take_nmi_o` are 0 whenever `take_o` is 0.
- R10: Synchronous reset sets the mask to 0 and clears `take_o`. After reset, only level 0 is accepted.
- R11: When a mask load and a boundary fall on the same edge, the newly loaded value is the one compared against the level and then decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-complete strobe |
| mreq_n_i | input | 1 | Maskable request, active low |
| mlevel_i | input | 4 | Priority level of the maskable request |
| nmi_n_i | input | 1 | Non-maskable request, active low |
| mask_load_i | input | 1 | Load-mask-immediate command |
| mask_value_i | input | 4 | Value for the mask load |
| take_o | output | 1 | One-clock interrupt take pulse |
| take_nmi_o | output | 1 | Take is the non-maskable request |
| vector_o | output | 16 | Vector word address of the take |
| mask_o | output | 4 | Current mask value |

## Verification
Every result registers on the edge that samples its inputs. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, half a cycle after the rising edge that updates them.

A mask load appears on `mask_o` one cycle after the load command. A take shows on `take_o`, `vector_o` and `mask_o` one cycle after the boundary strobe. The bench checks one cycle later again that the pulse has gone.

The sweep covers all 256 pairs of mask and level, and the expected vector and mask are computed arithmetically for each pair. Separate sequences cover back-to-back retakes, requests held without a strobe, the priority of the non-maskable line and a mask load that coincides with a boundary.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int LVL_W  = 4;
    localparam int ADDR_W = 16;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_MASKABLE = 2'd1,
        SRC_NMI      = 2'd2
    } src_e;

    typedef struct packed {
        src_e  src;
        addr_t vec;
    } decision_t;

    function automatic addr_t level_vector(lvl_t lvl, int shift);
        return addr_t'(lvl) << shift;
    endfunction

    function automatic lvl_t lowered_mask(lvl_t m);
        return (m == '0) ? m : lvl_t'(m - 1'b1);
    endfunction

endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int    VEC_SHIFT  = 2,
    parameter addr_t NMI_VECTOR = 16'hFFFC
) (
    input  logic      boundary_i,
    input  logic      mreq_n_i,
    input  lvl_t      mlevel_i,
    input  logic      nmi_n_i,
    input  lvl_t      eff_mask_i,
    output decision_t dec_o
);
    logic nmi_hit;
    logic mask_hit;

    always_comb begin
        nmi_hit  = boundary_i && !nmi_n_i;
        mask_hit = boundary_i && !mreq_n_i && (mlevel_i <= eff_mask_i);
        dec_o    = '{src: SRC_NONE, vec: '0};
        if (nmi_hit) begin
            dec_o.src = SRC_NMI;
            dec_o.vec = NMI_VECTOR;
        end else if (mask_hit) begin
            dec_o.src = SRC_MASKABLE;
            dec_o.vec = level_vector(mlevel_i, VEC_SHIFT);
        end
    end
endmodule

// File: rtl/irqv_mask_unit.sv
module irqv_mask_unit
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  lvl_t load_value_i,
    input  logic lower_i,
    output lvl_t eff_mask_o,
    output lvl_t mask_q_o
);
    lvl_t mask_q;
    lvl_t mask_d;

    always_comb begin
        eff_mask_o = load_i ? load_value_i : mask_q;
        mask_d     = lower_i ? lowered_mask(eff_mask_o) : eff_mask_o;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    assign mask_q_o = mask_q;
endmodule

// File: rtl/irqv_take_reg.sv
module irqv_take_reg
    import irqv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec_i,
    output logic      take_o,
    output logic      take_nmi_o,
    output addr_t     vector_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            take_nmi_o <= 1'b0;
            vector_o   <= '0;
        end else begin
            take_o     <= (dec_i.src != SRC_NONE);
            take_nmi_o <= (dec_i.src == SRC_NMI);
            vector_o   <= dec_i.vec;
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int    VEC_SHIFT  = 2,
    parameter addr_t NMI_VECTOR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              mreq_n_i,
    input  logic [LVL_W-1:0]  mlevel_i,
    input  logic              nmi_n_i,
    input  logic              mask_load_i,
    input  logic [LVL_W-1:0]  mask_value_i,
    output logic              take_o,
    output logic              take_nmi_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [LVL_W-1:0]  mask_o
);
    lvl_t      eff_mask;
    decision_t dec;

    irqv_arbiter #(.VEC_SHIFT(VEC_SHIFT), .NMI_VECTOR(NMI_VECTOR)) arb_i (
        .boundary_i (boundary_i),
        .mreq_n_i   (mreq_n_i),
        .mlevel_i   (mlevel_i),
        .nmi_n_i    (nmi_n_i),
        .eff_mask_i (eff_mask),
        .dec_o      (dec)
    );

    irqv_mask_unit mask_i (
        .clk          (clk),
        .rst          (rst),
        .load_i       (mask_load_i),
        .load_value_i (mask_value_i),
        .lower_i      (dec.src == SRC_MASKABLE),
        .eff_mask_o   (eff_mask),
        .mask_q_o     (mask_o)
    );

    irqv_take_reg take_i (
        .clk        (clk),
        .rst        (rst),
        .dec_i      (dec),
        .take_o     (take_o),
        .take_nmi_o (take_nmi_o),
        .vector_o   (vector_o)
    );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  boundary_i,
    input logic  mreq_n_i,
    input lvl_t  mlevel_i,
    input logic  nmi_n_i,
    input logic  mask_load_i,
    input lvl_t  mask_value_i,
    input logic  take_o,
    input logic  take_nmi_o,
    input addr_t vector_o,
    input lvl_t  mask_o
);
    assert_take_needs_boundary_R1: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(boundary_i) && (!$past(nmi_n_i) || !$past(mreq_n_i)));

    assert_level_within_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (take_o && !take_nmi_o) |->
        ($past(mlevel_i) <= ($past(mask_load_i) ? $past(mask_value_i) : $past(mask_o))));

    assert_vector_is_level_x4_R3: assert property (@(posedge clk) disable iff (rst)
        (take_o && !take_nmi_o) |-> (vector_o == {10'd0, $past(mlevel_i), 2'b00}));

    assert_mask_lowered_R4: assert property (@(posedge clk) disable iff (rst)
        (take_o && !take_nmi_o && !$past(mask_load_i) && $past(mask_o) != 0)
        |-> (mask_o == $past(mask_o) - 4'd1));

    assert_nmi_vector_R6: assert property (@(posedge clk) disable iff (rst)
        take_nmi_o |-> (take_o && vector_o == 16'hFFFC));

    assert_nmi_priority_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(boundary_i) && !$past(nmi_n_i)) |-> take_nmi_o);

    assert_idle_outputs_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vector_o == 16'h0000 && !take_nmi_o));

    assert_reset_mask_R10: assert property (@(posedge clk)
        $past(rst) |-> (mask_o == 4'd0 && !take_o));
endmodule

bind irq_vector_unit irqv_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .boundary_i   (boundary_i),
    .mreq_n_i     (mreq_n_i),
    .mlevel_i     (mlevel_i),
    .nmi_n_i      (nmi_n_i),
    .mask_load_i  (mask_load_i),
    .mask_value_i (mask_value_i),
    .take_o       (take_o),
    .take_nmi_o   (take_nmi_o),
    .vector_o     (vector_o),
    .mask_o       (mask_o)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 1'b0;
    logic        mreq_n_i = 1'b1;
    logic [3:0]  mlevel_i = '0;
    logic        nmi_n_i = 1'b1;
    logic        mask_load_i = 1'b0;
    logic [3:0]  mask_value_i = '0;
    logic        take_o;
    logic        take_nmi_o;
    logic [15:0] vector_o;
    logic [3:0]  mask_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_unit dut_i (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .mreq_n_i(mreq_n_i),
        .mlevel_i(mlevel_i), .nmi_n_i(nmi_n_i), .mask_load_i(mask_load_i),
        .mask_value_i(mask_value_i), .take_o(take_o), .take_nmi_o(take_nmi_o),
        .vector_o(vector_o), .mask_o(mask_o)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic load_mask(int m);
        @(negedge clk);
        mask_load_i = 1'b1; mask_value_i = 4'(m);
        @(negedge clk);
        mask_load_i = 1'b0;
    endtask

    // One boundary strobe with the given request levels; results read a cycle later.
    task automatic strobe(bit mreq, int lvl, bit nmi);
        @(negedge clk);
        mreq_n_i = ~mreq; mlevel_i = 4'(lvl); nmi_n_i = ~nmi; boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0; mreq_n_i = 1'b1; nmi_n_i = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10 mask", mask_o, 0);
        check("R10 take", take_o, 0);
        strobe(1, 1, 0);
        check("R10 level1 rejected", take_o, 0);
        strobe(1, 0, 0);
        check("R10 level0 taken", take_o, 1);
        check("R10 level0 vector", vector_o, 0);

        // R2 R3 R4 R5 R9: all mask/level pairs
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 16; l++) begin
                bit acc;
                load_mask(m);
                check("R5 mask load", mask_o, m);
                strobe(1, l, 0);
                acc = (l <= m);
                check("R2 accept", take_o, int'(acc));
                check("R3 vector", vector_o, acc ? l * 4 : 0);
                check("R4 mask after", mask_o, (acc && m != 0) ? m - 1 : m);
                check("R9 nmi flag", take_nmi_o, 0);
                @(negedge clk);
                check("R9 single pulse", take_o, 0);
            end
        end

        // R1: request held low without boundary, and boundary with lines idle
        load_mask(15);
        @(negedge clk);
        mreq_n_i = 1'b0; mlevel_i = 4'd3; nmi_n_i = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R1 no strobe", take_o, 0);
        end
        mreq_n_i = 1'b1; nmi_n_i = 1'b1;
        strobe(0, 3, 0);
        check("R1 idle lines", take_o, 0);
        check("R1 mask kept", mask_o, 15);

        // R7: held request retaken at each boundary until mask excludes it
        load_mask(3);
        for (int k = 0; k < 4; k++) begin
            strobe(1, 1, 0);
            check("R7 retake", take_o, (k < 3) ? 1 : 0);
            check("R7 mask", mask_o, (k < 3) ? 2 - k : 0);
        end

        // R8: both pending, NMI wins and mask stays
        load_mask(15);
        strobe(1, 2, 1);
        check("R8 take", take_o, 1);
        check("R8 nmi flag", take_nmi_o, 1);
        check("R8 vector", vector_o, 16'hFFFC);
        check("R8 mask kept", mask_o, 15);

        // R6: NMI taken at mask 0, retaken, mask unchanged
        load_mask(0);
        for (int k = 0; k < 3; k++) begin
            strobe(0, 0, 1);
            check("R6 take", take_o, 1);
            check("R6 vector", vector_o, 16'hFFFC);
            check("R6 mask", mask_o, 0);
        end

        // R11: load and boundary on the same edge
        load_mask(0);
        @(negedge clk);
        mask_load_i = 1'b1; mask_value_i = 4'd5;
        mreq_n_i = 1'b0; mlevel_i = 4'd3; boundary_i = 1'b1;
        @(negedge clk);
        mask_load_i = 1'b0; mreq_n_i = 1'b1; boundary_i = 1'b0;
        check("R11 take", take_o, 1);
        check("R11 vector", vector_o, 12);
        check("R11 mask", mask_o, 4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule